// File: doc/BRIEF.md
# Linked-List Descriptor Loader

This block walks a chain of transfer descriptors stored in word-addressed memory. It fetches one 32-bit word at a time over a simple read port and loads each word into the configuration registers of one logical channel. Once a descriptor is in, the block starts the data transfer. When the transfer reports completion, the block follows the next pointer to the following descriptor.

A descriptor's length is not fixed. It depends on the descriptor's type and on two address-update codes, one for the source address and one for the destination address. Each code picks one of three behaviours:

- a fresh address word is present in the descriptor;
- the address carries on from where the previous transfer ended;
- the stored address is kept as it is.

Each descriptor carries the layout of the one after it. A pause flag can hold the channel after a load until software releases it. The data engine is not part of the block; it only returns its end addresses with a completion pulse.

Top module: `ll_desc_loader`

## Requirements
- R1: Word k of a descriptor at pointer P is fetched from byte address {P[31:2],2'b00} + 4k. The two low bits of both the start pointer and any loaded next pointer are forced to zero.
- R2: A read request holds its address until the cycle it is accepted (mem_req && mem_ack). No new request is raised before the read data of the previous one has returned with mem_rvalid. A word is consumed only on mem_rvalid.
- R3: Descriptor word order is: next-pointer word, link word, source address (only when the source code is new), destination address (only when the destination code is new), then the type words. Type code 2'b01 (and 2'b00) is type 1 and carries index, count, control and mask words. Type 2'b10 is type 2 and carries count, control and mask. Type 2'b11 is type 3 and carries count and control. The count takes the low CNT_W bits of its word; the control word is taken whole.
- R4: Address code 2'b10 (new) loads the address from its descriptor word.
- R5: Address code 2'b01 (continue) sets the address to the end address returned by the most recent completed transfer, including one from an earlier list.
- R6: Address code 2'b00 or 2'b11 (keep) leaves the stored address unchanged.
- R7: The type 1 index word puts the source index in bits 15:0 and the destination index in bits 31:16. Types 2 and 3 leave both indexes unchanged.
- R8: Types 1 and 2 load the whole interrupt mask from bits IRQ_W-1:0 of the mask word. The block-enable flag in the link word has no effect for them.
- R9: For type 3, mask bit BLOCK_BIT takes the link word's block-enable flag (bit 7). All other mask bits keep their values.
- R10: Link word bits 1:0, 3:2 and 5:4 give the type, source code and destination code of the next descriptor. The start inputs give them for the first descriptor.
- R11: If link word bit 6 (pause) is set, the block raises paused after the load and neither fetches nor starts a transfer until a pause_clr pulse. It then goes on with the transfer. pause_clr has no effect outside the paused state.
- R12: xfer_start is a one-cycle pulse after each load, and after the release when the load was paused. A next-pointer word whose bits 31:2 are all ones ends the list. After that descriptor's xfer_done, list_done pulses for one cycle and busy falls.
- R13: After reset mem_req, busy, paused, xfer_start and list_done are low, and all loaded registers are zero.
- R14: start is ignored while busy. xfer_done is ignored unless a transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin walking a list (idle only) |
| start_ptr | input | 32 | Byte address of first descriptor |
| start_type | input | 2 | Type code of first descriptor |
| start_src_mode | input | 2 | Source address code of first descriptor |
| start_dst_mode | input | 2 | Destination address code of first descriptor |
| pause_clr | input | 1 | Software release of a paused channel |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read byte address, word aligned |
| mem_ack | input | 1 | Request accepted |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid, at least one cycle after acceptance |
| xfer_start | output | 1 | Data transfer may start |
| xfer_done | input | 1 | Data transfer finished |
| xfer_src_end | input | 32 | Source address following the transfer |
| xfer_dst_end | input | 32 | Destination address following the transfer |
| src_addr | output | 32 | Channel source address |
| dst_addr | output | 32 | Channel destination address |
| src_index | output | 16 | Source element index |
| dst_index | output | 16 | Destination element index |
| elem_count | output | CNT_W | Element count |
| xfer_ctrl | output | 32 | Channel control word |
| irq_mask | output | IRQ_W | Interrupt enable mask |
| next_ptr | output | 32 | Aligned next-descriptor pointer |
| busy | output | 1 | List walk in progress |
| paused | output | 1 | Channel suspended after a load |
| list_done | output | 1 | One-cycle pulse at end of list |

## Verification
The bench builds the loader with CNT_W=16, IRQ_W=16 and BLOCK_BIT=5. Placing the block-enable bit in the middle of the mask lets one value show both a set and a cleared bit beside untouched neighbours. The chains use all three types, all three address codes, a paused descriptor, unaligned pointers and a continue across two lists. Memory latency alternates, so requests are held for several cycles.

// File: rtl/ll_desc_pkg.sv
package ll_desc_pkg;

   // address-update code carried per descriptor for source and destination
   typedef enum logic [1:0] {
      MODE_KEEP = 2'b00,
      MODE_CONT = 2'b01,
      MODE_NEW  = 2'b10,
      MODE_RSVD = 2'b11
   } addr_mode_e;

   // role of one descriptor word
   typedef enum logic [2:0] {
      WK_PTR,
      WK_LINK,
      WK_SRC,
      WK_DST,
      WK_IDX,
      WK_CNT,
      WK_CTL,
      WK_MSK
   } word_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PREP,
      ST_LOAD,
      ST_HOLD,
      ST_GO,
      ST_RUN
   } ld_state_e;

   // link word field positions
   localparam int unsigned LNK_TYPE_LSB = 0;
   localparam int unsigned LNK_SRC_LSB  = 2;
   localparam int unsigned LNK_DST_LSB  = 4;
   localparam int unsigned LNK_PAUSE    = 6;
   localparam int unsigned LNK_BLOCK    = 7;

   localparam int unsigned MAX_DESC_WORDS = 8;

   // number of trailing type-dependent words
   function automatic logic [2:0] type_words(input logic [1:0] ty);
      case (ty)
         2'b11:   return 3'd2;
         2'b10:   return 3'd3;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/ll_desc_layout.sv
module ll_desc_layout
   import ll_desc_pkg::*;
#(
   parameter int unsigned IDX_W = 3
) (
   input  logic [1:0]       desc_type,
   input  logic [1:0]       src_mode,
   input  logic [1:0]       dst_mode,
   input  logic [IDX_W-1:0] word_idx,
   output word_kind_e       kind,
   output logic             last
);

   localparam int unsigned CW = IDX_W + 1;

   logic          s_new;
   logic          d_new;
   logic [CW-1:0] total;
   logic [CW-1:0] j;
   logic [CW-1:0] idx_ext;

   assign s_new   = (src_mode == MODE_NEW);
   assign d_new   = (dst_mode == MODE_NEW);
   assign idx_ext = {1'b0, word_idx};
   assign total   = CW'(2) + CW'(s_new) + CW'(d_new) + CW'(type_words(desc_type));
   assign last    = (idx_ext == total - CW'(1));

   always_comb begin
      kind = WK_PTR;
      j    = idx_ext - CW'(2);
      if (idx_ext == CW'(0)) begin
         kind = WK_PTR;
      end else if (idx_ext == CW'(1)) begin
         kind = WK_LINK;
      end else if (s_new && (j == CW'(0))) begin
         kind = WK_SRC;
      end else begin
         if (s_new) j = j - CW'(1);
         if (d_new && (j == CW'(0))) begin
            kind = WK_DST;
         end else begin
            if (d_new) j = j - CW'(1);
            case (desc_type)
               2'b11:   kind = (j == CW'(0)) ? WK_CNT : WK_CTL;
               2'b10:   kind = (j == CW'(0)) ? WK_CNT :
                               (j == CW'(1)) ? WK_CTL : WK_MSK;
               default: kind = (j == CW'(0)) ? WK_IDX :
                               (j == CW'(1)) ? WK_CNT :
                               (j == CW'(2)) ? WK_CTL : WK_MSK;
            endcase
         end
      end
   end

endmodule

// File: rtl/ll_read_port.sv
module ll_read_port #(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          want,
   input  logic [AW-1:0] addr_in,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata,
   output logic          word_valid,
   output logic [DW-1:0] word_data
);

   logic          req_q;
   logic          wait_q;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         wait_q <= 1'b0;
         addr_q <= '0;
      end else if (!req_q && !wait_q && want) begin
         req_q  <= 1'b1;
         addr_q <= addr_in;
      end else if (req_q && mem_ack) begin
         req_q  <= 1'b0;
         wait_q <= 1'b1;
      end else if (wait_q && mem_rvalid) begin
         wait_q <= 1'b0;
      end
   end

   assign mem_req    = req_q;
   assign mem_addr   = addr_q;
   assign word_valid = wait_q && mem_rvalid;
   assign word_data  = mem_rdata;

endmodule

// File: rtl/ll_cfg_regs.sv
module ll_cfg_regs
   import ll_desc_pkg::*;
#(
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned IRQ_W     = 16,
   parameter int unsigned BLOCK_BIT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  word_kind_e       kind,
   input  logic [31:0]      data,
   input  logic             prep,
   input  logic [1:0]       src_mode,
   input  logic [1:0]       dst_mode,
   input  logic [31:0]      src_last,
   input  logic [31:0]      dst_last,
   input  logic             load_end,
   input  logic             is_type3,
   input  logic             hold_clr,
   output logic [31:0]      src_addr,
   output logic [31:0]      dst_addr,
   output logic [15:0]      src_index,
   output logic [15:0]      dst_index,
   output logic [CNT_W-1:0] elem_count,
   output logic [31:0]      xfer_ctrl,
   output logic [IRQ_W-1:0] irq_mask,
   output logic [31:0]      next_ptr,
   output logic             list_end,
   output logic [1:0]       nxt_type,
   output logic [1:0]       nxt_src,
   output logic [1:0]       nxt_dst,
   output logic             pause_bit,
   output logic             block_en
);

   logic wr_msk;
   assign wr_msk = wr && (kind == WK_MSK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_addr   <= '0;
         dst_addr   <= '0;
         src_index  <= '0;
         dst_index  <= '0;
         elem_count <= '0;
         xfer_ctrl  <= '0;
         next_ptr   <= '0;
         list_end   <= 1'b0;
         nxt_type   <= '0;
         nxt_src    <= '0;
         nxt_dst    <= '0;
         pause_bit  <= 1'b0;
         block_en   <= 1'b0;
      end else begin
         if (prep) begin
            if (src_mode == MODE_CONT) src_addr <= src_last;
            if (dst_mode == MODE_CONT) dst_addr <= dst_last;
         end
         if (hold_clr) pause_bit <= 1'b0;
         if (wr) begin
            case (kind)
               WK_PTR: begin
                  next_ptr <= {data[31:2], 2'b00};
                  list_end <= &data[31:2];
               end
               WK_LINK: begin
                  nxt_type  <= data[LNK_TYPE_LSB +: 2];
                  nxt_src   <= data[LNK_SRC_LSB +: 2];
                  nxt_dst   <= data[LNK_DST_LSB +: 2];
                  pause_bit <= data[LNK_PAUSE];
                  block_en  <= data[LNK_BLOCK];
               end
               WK_SRC: src_addr <= data;
               WK_DST: dst_addr <= data;
               WK_IDX: begin
                  src_index <= data[15:0];
                  dst_index <= data[31:16];
               end
               WK_CNT: elem_count <= data[CNT_W-1:0];
               WK_CTL: xfer_ctrl  <= data;
               default: ;
            endcase
         end
      end
   end

   // one flop per mask bit; the block-enable bit alone also follows type 3 loads
   for (genvar b = 0; b < IRQ_W; b++) begin : g_mask
      logic bit_q;
      if (b == BLOCK_BIT) begin : g_blk
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    bit_q <= 1'b0;
            else if (wr_msk)               bit_q <= data[b];
            else if (load_end && is_type3) bit_q <= block_en;
         end
      end else begin : g_std
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      bit_q <= 1'b0;
            else if (wr_msk) bit_q <= data[b];
         end
      end
      assign irq_mask[b] = bit_q;
   end

endmodule

// File: rtl/ll_desc_loader.sv
module ll_desc_loader
   import ll_desc_pkg::*;
#(
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned IRQ_W     = 16,
   parameter int unsigned BLOCK_BIT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [31:0]      start_ptr,
   input  logic [1:0]       start_type,
   input  logic [1:0]       start_src_mode,
   input  logic [1:0]       start_dst_mode,
   input  logic             pause_clr,
   output logic             mem_req,
   output logic [31:0]      mem_addr,
   input  logic             mem_ack,
   input  logic [31:0]      mem_rdata,
   input  logic             mem_rvalid,
   output logic             xfer_start,
   input  logic             xfer_done,
   input  logic [31:0]      xfer_src_end,
   input  logic [31:0]      xfer_dst_end,
   output logic [31:0]      src_addr,
   output logic [31:0]      dst_addr,
   output logic [15:0]      src_index,
   output logic [15:0]      dst_index,
   output logic [CNT_W-1:0] elem_count,
   output logic [31:0]      xfer_ctrl,
   output logic [IRQ_W-1:0] irq_mask,
   output logic [31:0]      next_ptr,
   output logic             busy,
   output logic             paused,
   output logic             list_done
);

   localparam int unsigned IDX_W = $clog2(MAX_DESC_WORDS);

   if (IRQ_W < 1 || IRQ_W > 32) begin : g_bad_irq_w
      $error("IRQ_W must be within 1..32");
   end
   if (BLOCK_BIT >= IRQ_W) begin : g_bad_block_bit
      $error("BLOCK_BIT must index a mask bit");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("CNT_W must be within 1..32");
   end

   ld_state_e        state;
   logic [1:0]       cur_type;
   logic [1:0]       cur_src;
   logic [1:0]       cur_dst;
   logic [31:0]      desc_ptr;
   logic [IDX_W-1:0] word_idx;
   logic [31:0]      src_last;
   logic [31:0]      dst_last;
   logic             done_q;

   word_kind_e  kind;
   logic        last_word;
   logic        word_valid;
   logic [31:0] word_data;
   logic [31:0] fetch_addr;
   logic        list_end;
   logic [1:0]  nxt_type;
   logic [1:0]  nxt_src;
   logic [1:0]  nxt_dst;
   logic        pause_bit;
   logic        block_en;
   logic        load_fin;

   assign fetch_addr = desc_ptr + (32'(word_idx) << 2);
   assign load_fin   = (state == ST_LOAD) && word_valid && last_word;

   ll_desc_layout #(.IDX_W(IDX_W)) u_layout (
      .desc_type (cur_type),
      .src_mode  (cur_src),
      .dst_mode  (cur_dst),
      .word_idx  (word_idx),
      .kind      (kind),
      .last      (last_word)
   );

   ll_read_port #(.AW(32), .DW(32)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .want       (state == ST_LOAD),
      .addr_in    (fetch_addr),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_ack    (mem_ack),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .word_valid (word_valid),
      .word_data  (word_data)
   );

   ll_cfg_regs #(.CNT_W(CNT_W), .IRQ_W(IRQ_W), .BLOCK_BIT(BLOCK_BIT)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         ((state == ST_LOAD) && word_valid),
      .kind       (kind),
      .data       (word_data),
      .prep       (state == ST_PREP),
      .src_mode   (cur_src),
      .dst_mode   (cur_dst),
      .src_last   (src_last),
      .dst_last   (dst_last),
      .load_end   (load_fin),
      .is_type3   (cur_type == 2'b11),
      .hold_clr   ((state == ST_HOLD) && pause_clr),
      .src_addr   (src_addr),
      .dst_addr   (dst_addr),
      .src_index  (src_index),
      .dst_index  (dst_index),
      .elem_count (elem_count),
      .xfer_ctrl  (xfer_ctrl),
      .irq_mask   (irq_mask),
      .next_ptr   (next_ptr),
      .list_end   (list_end),
      .nxt_type   (nxt_type),
      .nxt_src    (nxt_src),
      .nxt_dst    (nxt_dst),
      .pause_bit  (pause_bit),
      .block_en   (block_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_type <= '0;
         cur_src  <= '0;
         cur_dst  <= '0;
         desc_ptr <= '0;
         word_idx <= '0;
         src_last <= '0;
         dst_last <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               cur_type <= start_type;
               cur_src  <= start_src_mode;
               cur_dst  <= start_dst_mode;
               desc_ptr <= {start_ptr[31:2], 2'b00};
               state    <= ST_PREP;
            end
            ST_PREP: begin
               word_idx <= '0;
               state    <= ST_LOAD;
            end
            ST_LOAD: if (word_valid) begin
               if (last_word) state <= pause_bit ? ST_HOLD : ST_GO;
               else           word_idx <= word_idx + IDX_W'(1);
            end
            ST_HOLD: if (pause_clr) state <= ST_GO;
            ST_GO:   state <= ST_RUN;
            ST_RUN: if (xfer_done) begin
               src_last <= xfer_src_end;
               dst_last <= xfer_dst_end;
               if (list_end) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  cur_type <= nxt_type;
                  cur_src  <= nxt_src;
                  cur_dst  <= nxt_dst;
                  desc_ptr <= next_ptr;
                  state    <= ST_PREP;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state != ST_IDLE);
   assign paused     = (state == ST_HOLD);
   assign xfer_start = (state == ST_GO);
   assign list_done  = done_q;

endmodule

// File: rtl/ll_desc_loader_chk.sv
module ll_desc_loader_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        mem_req,
   input logic [31:0] mem_addr,
   input logic        mem_ack,
   input logic        mem_rvalid,
   input logic        xfer_start,
   input logic        paused,
   input logic        busy,
   input logic        list_done
);

   logic outst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  outst <= 1'b0;
      else if (mem_req && mem_ack) outst <= 1'b1;
      else if (mem_rvalid)         outst <= 1'b0;
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R2
   AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      outst |-> !mem_req); // R2
   AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00); // R1
   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      paused |-> !xfer_start && !mem_req); // R11
   AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start); // R12
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      list_done |-> !busy); // R12
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      list_done |=> !list_done); // R12

endmodule

bind ll_desc_loader ll_desc_loader_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_ack    (mem_ack),
   .mem_rvalid (mem_rvalid),
   .xfer_start (xfer_start),
   .paused     (paused),
   .busy       (busy),
   .list_done  (list_done)
);

// File: tb/ll_desc_loader_test.sv
module ll_desc_loader_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_ptr = '0;
   logic [1:0]  start_type = '0;
   logic [1:0]  start_src_mode = '0;
   logic [1:0]  start_dst_mode = '0;
   logic        pause_clr = 1'b0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mem_rvalid = 1'b0;
   logic        xfer_start;
   logic        xfer_done = 1'b0;
   logic [31:0] xfer_src_end = '0;
   logic [31:0] xfer_dst_end = '0;
   logic [31:0] src_addr, dst_addr, xfer_ctrl, next_ptr;
   logic [15:0] src_index, dst_index, elem_count, irq_mask;
   logic        busy, paused, list_done;

   always #5 clk = ~clk;

   ll_desc_loader #(.CNT_W(16), .IRQ_W(16), .BLOCK_BIT(5)) uut (.*);

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   typedef struct {
      logic [31:0] src, dst, ctl;
      logic [15:0] sidx, didx, cnt, msk;
      bit          pz;
      string       stag, dtag, mtag;
   } exp_t;

   logic [31:0] mem [0:63];
   logic [31:0] exp_fetch [$];
   exp_t        exp_q [$];

   // bench model of channel state
   logic [31:0] m_src = '0, m_dst = '0, m_send = '0, m_dend = '0;
   logic [15:0] m_sidx = '0, m_didx = '0, m_cnt = '0, m_msk = '0;
   logic [31:0] m_ctl = '0;

   function automatic string mode_tag(input logic [1:0] m);
      return (m == 2'b10) ? "R4" : (m == 2'b01) ? "R5" : "R6";
   endfunction

   // driver: writes one descriptor, pushes expected fetches and register set
   task automatic put_desc(input logic [31:0] at, input logic [1:0] ty, sm, dm,
                           input logic [31:0] nxt, input logic [1:0] nty, nsm, ndm,
                           input bit pz, blk,
                           input logic [31:0] s, d, idx, cnt, ctl, msk);
      logic [31:0] w [$];
      exp_t e;
      w.push_back(nxt);
      w.push_back({24'd0, blk, pz, ndm, nsm, nty});
      if (sm == 2'b10) w.push_back(s);
      if (dm == 2'b10) w.push_back(d);
      if (ty == 2'b01) w.push_back(idx);
      w.push_back(cnt);
      w.push_back(ctl);
      if (ty != 2'b11) w.push_back(msk);
      foreach (w[k]) begin
         mem[(at >> 2) + k] = w[k];
         exp_fetch.push_back({at[31:2], 2'b00} + 32'(k) * 4);
      end
      if (sm == 2'b10) m_src = s; else if (sm == 2'b01) m_src = m_send;
      if (dm == 2'b10) m_dst = d; else if (dm == 2'b01) m_dst = m_dend;
      if (ty == 2'b01) begin m_sidx = idx[15:0]; m_didx = idx[31:16]; end
      m_cnt = cnt[15:0];
      m_ctl = ctl;
      if (ty == 2'b11) m_msk[5] = blk; else m_msk = msk[15:0];
      m_send = m_src + 32'h40;
      m_dend = m_dst + 32'h80;
      e.src = m_src; e.dst = m_dst; e.sidx = m_sidx; e.didx = m_didx;
      e.cnt = m_cnt; e.ctl = m_ctl; e.msk = m_msk; e.pz = pz;
      e.stag = mode_tag(sm); e.dtag = mode_tag(dm);
      e.mtag = (ty == 2'b11) ? "R9" : "R8";
      exp_q.push_back(e);
   endtask

   // memory responder with alternating latency
   int rsp_cnt = 0;
   initial begin
      logic [31:0] a;
      forever begin
         @(negedge clk);
         if (mem_req) begin
            if (rsp_cnt % 2 == 1) @(negedge clk);
            mem_ack = 1'b1;
            a = mem_addr;
            @(negedge clk);
            mem_ack = 1'b0;
            if (rsp_cnt % 3 == 0) @(negedge clk);
            rsp_cnt++;
            if (exp_fetch.size() == 0) chk("R3 extra fetch", a, 32'hFFFF_FFFF);
            else chk("R1 R3 R10 fetch address", a, exp_fetch.pop_front());
            mem_rdata  = mem[a[7:2]];
            mem_rvalid = 1'b1;
            @(negedge clk);
            mem_rvalid = 1'b0;
         end
      end
   end

   // pause observer: checks the hold, then releases
   int pause_seen = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (paused) begin
            pause_seen++;
            for (int i = 0; i < 4; i++) begin
               @(negedge clk);
               chk("R11 held while paused", {30'd0, xfer_start, mem_req}, 32'd0);
            end
            pause_clr = 1'b1;
            @(negedge clk);
            pause_clr = 1'b0;
         end
      end
   end

   // monitor / data engine: compares each loaded set, then completes the transfer
   int spur_ask = 0, spur_served = 0, pause_used = 0;
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (xfer_start) begin
            if (exp_q.size() == 0) begin
               chk("R12 unexpected start", 32'd1, 32'd0);
            end else begin
               e = exp_q.pop_front();
               chk(e.stag, src_addr, e.src);
               chk(e.dtag, dst_addr, e.dst);
               chk("R7 src index", 32'(src_index), 32'(e.sidx));
               chk("R7 dst index", 32'(dst_index), 32'(e.didx));
               chk("R3 count", 32'(elem_count), 32'(e.cnt));
               chk("R3 control", xfer_ctrl, e.ctl);
               chk(e.mtag, 32'(irq_mask), 32'(e.msk));
               chk("R11 pause seen", 32'(pause_seen - pause_used), 32'(e.pz));
               pause_used = pause_seen;
               @(negedge clk);
               chk("R12 start pulse width", 32'(xfer_start), 32'd0);
               repeat (2) @(negedge clk);
               xfer_src_end = e.src + 32'h40;
               xfer_dst_end = e.dst + 32'h80;
               xfer_done    = 1'b1;
               @(negedge clk);
               xfer_done = 1'b0;
            end
         end else if (spur_ask != spur_served && busy && mem_req) begin
            xfer_src_end = 32'hDEAD_0000;
            xfer_dst_end = 32'hDEAD_0000;
            xfer_done    = 1'b1;
            @(negedge clk);
            xfer_done = 1'b0;
            spur_served++;
         end
      end
   end

   task automatic kick(input logic [31:0] p, input logic [1:0] ty, sm, dm);
      @(negedge clk);
      start_ptr = p; start_type = ty; start_src_mode = sm; start_dst_mode = dm;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      bit seen = 0;
      for (int i = 0; i < 3000 && !seen; i++) begin
         @(negedge clk);
         if (list_done) seen = 1;
      end
      chk({tag, " R12 list_done"}, 32'(seen), 32'd1);
      chk({tag, " R12 idle after end"}, 32'(busy), 32'd0);
      chk({tag, " R3 fetches consumed"}, 32'(exp_fetch.size()), 32'd0);
      chk({tag, " R12 sets consumed"}, 32'(exp_q.size()), 32'd0);
      @(negedge clk);
      chk({tag, " R12 done pulse width"}, 32'(list_done), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      chk("R13 reset outputs", {26'd0, mem_req, busy, paused, xfer_start, list_done, 1'b0}, 32'd0);
      chk("R13 reset src", src_addr, 32'd0);
      chk("R13 reset mask", 32'(irq_mask), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R13 idle after reset", {30'd0, busy, mem_req}, 32'd0);
      chk("R13 next pointer", next_ptr, 32'd0);

      // list A: type 1 -> type 2 (paused) -> type 3 end; unaligned pointers
      put_desc(32'h10, 2'b01, 2'b10, 2'b10, 32'h43, 2'b10, 2'b01, 2'b00, 0, 1,
               32'h1000_0000, 32'h2000_0000, 32'h0008_0004, 32'h10, 32'hC0DE_0001, 32'h0000_A40F);
      put_desc(32'h40, 2'b10, 2'b01, 2'b00, 32'h62, 2'b11, 2'b00, 2'b10, 1, 0,
               32'h0, 32'h0, 32'h0, 32'h20, 32'h2, 32'h0000_1234);
      put_desc(32'h60, 2'b11, 2'b00, 2'b10, 32'hFFFF_FFFF, 2'b01, 2'b00, 2'b00, 0, 0,
               32'h0, 32'h3000_0000, 32'h0, 32'h30, 32'h3, 32'h0);
      kick(32'h13, 2'b01, 2'b10, 2'b10);
      spur_ask++;
      repeat (3) @(negedge clk);
      start_ptr = 32'hC0;  // R14: restart attempt while busy
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done("list A");

      // pause release outside the paused state has no effect (R11)
      pause_clr = 1'b1;
      @(negedge clk);
      pause_clr = 1'b0;
      chk("R11 stray release ignored", {30'd0, busy, paused}, 32'd0);

      // list B: type 3 set block bit, continue across lists, then type 3 clear
      put_desc(32'h80, 2'b11, 2'b00, 2'b01, 32'hA0, 2'b11, 2'b10, 2'b00, 0, 1,
               32'h0, 32'h0, 32'h0, 32'h40, 32'h4, 32'h0);
      put_desc(32'hA0, 2'b11, 2'b10, 2'b00, 32'hFFFF_FFFF, 2'b00, 2'b00, 2'b00, 0, 0,
               32'h5000_0000, 32'h0, 32'h0, 32'h50, 32'h5, 32'h0);
      kick(32'h82, 2'b11, 2'b00, 2'b01);
      wait_done("list B");
      chk("R14 spurious done ignored", 32'(spur_served), 32'd1);
      wrap_up();
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      wrap_up();
   end

endmodule